// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block turns a bit-rate clock enable into a repeating frame-sync pulse train. Two fields set the waveform. A period field fixes how many enabled cycles pass from the start of one pulse to the start of the next. A width field fixes how many enabled cycles each pulse stays high. Each field feeds its own reloading down-counter. Both counters advance only on cycles where the clock enable is high, so one fast clock can serve any divided bit rate.

A mode input picks where each frame starts. In internal mode the period counter starts every frame. In external mode the period counter is frozen and the period field is ignored. A frame then starts on a low-to-high transition of an external sync input, sampled on enabled cycles. In both modes the pulse length comes from the width field.

All pins are plain control and level signals. No data moves through the block, so it has no valid/ready interface and no back-pressure.

Top module: `fsg_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first cycle with `tick` high, `fs_out` is 0.
- R2: In internal mode (`ext_mode`=0), the first rising clock edge after reset that has `tick`=1 starts a pulse. `fs_out` is 1 right after that edge.
- R3: In internal mode, pulses start every `period_cfg`+1 enabled cycles. If the first start is enabled cycle 0, enabled cycle t is a start whenever t mod (`period_cfg`+1) = 0.
- R4: Each pulse keeps `fs_out` high for `width_cfg`+1 enabled cycles. In internal mode, `fs_out` after enabled cycle t is 1 exactly when (t mod (`period_cfg`+1)) <= `width_cfg`.
- R5: When `width_cfg` >= `period_cfg`, every new start reloads the width count, so `fs_out` stays 1 without a break.
- R6: On a clock edge with `tick`=0, neither counter and not `fs_out` changes.
- R7: A new `period_cfg` or `width_cfg` value takes effect at the next start. A period already being counted finishes with its old length.
- R8: In external mode (`ext_mode`=1), the period counter holds and `period_cfg` has no effect. No pulse starts unless the external sync input has a rising edge.
- R9: A rising edge is seen on an enabled cycle where `ext_sync` is 1 and was 0 at the previous enabled cycle. The previous sample resets to 1. The pulse starts right after that edge. A level held high does not start a second pulse.
- R10: In external mode, a rising edge during an active pulse restarts the width count. `fs_out` then stays high for `width_cfg`+1 enabled cycles from the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Generated bit-clock enable; counters move only when high |
| period_cfg | input | 12 | Frame period minus one, in enabled cycles |
| width_cfg | input | 8 | Pulse width minus one, in enabled cycles |
| ext_mode | input | 1 | 1 selects external frame start and holds the period counter |
| ext_sync | input | 1 | External frame trigger, rising-edge sensitive |
| fs_out | output | 1 | Active-high frame-sync pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that `ext_sync` needs no metastability protection inside the block. The bench meets this by changing every input only on the falling edge. It reads `fs_out` on the falling edge as well, half a cycle after each update. Configuration changes are made mid-frame on purpose, so the held-until-reload behaviour is exercised without breaking those assumptions.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic {
    FSG_MODE_INTERNAL = 1'b0,
    FSG_MODE_EXTERNAL = 1'b1
  } fsg_mode_e;

  localparam int FSG_PER_W_DEF = 12;
  localparam int FSG_WID_W_DEF = 8;
endpackage

// File: rtl/fsg_edge_detect.sv
module fsg_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    prev_q <= 1'b1;
    else if (tick) prev_q <= sig_in;
  end

  assign rise = tick & sig_in & ~prev_q;

  // R9: a level held high across two enabled cycles is not a second edge
  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sig_in) |=> !(tick && rise && $past(sig_in)));
endmodule

// File: rtl/fsg_period_counter.sv
module fsg_period_counter #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic [PER_W-1:0] reload_val,
  output logic             start
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);
  logic [PER_W-1:0] cnt_q;

  assign start = tick & ~hold & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick && !hold) begin
      if (cnt_q == '0) cnt_q <= reload_val;
      else             cnt_q <= cnt_q - ONE;
    end
  end

  // R7: a start loads the period value present at that edge
  assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(reload_val));
  // R8: the count is frozen while held
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));
  // R6: no movement without the enable
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/fsg_width_counter.sv
module fsg_width_counter #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [WID_W-1:0] load_val,
  output logic             active
);
  localparam logic [WID_W-1:0] ONE = WID_W'(1);
  logic [WID_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      act_q <= 1'b1;
    end else if (tick && act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - ONE;
    end
  end

  assign active = act_q;

  // R4: an expired width count without a new start ends the pulse
  assert_pulse_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_q && cnt_q == '0 && !start) |=> !act_q);
  // R5: a start always leaves the pulse active
  assert_start_asserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> act_q);
  // R6: output frozen on cycles without the enable
  assert_idle_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_q));
endmodule

// File: rtl/fsg_pulse_gen.sv
module fsg_pulse_gen
  import fsg_pkg::*;
#(
  parameter int PER_W = FSG_PER_W_DEF,
  parameter int WID_W = FSG_WID_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [WID_W-1:0] width_cfg,
  input  logic             ext_mode,
  input  logic             ext_sync,
  output logic             fs_out
);
  fsg_mode_e mode;
  logic      per_start;
  logic      ext_rise;
  logic      frame_start;

  assign mode = fsg_mode_e'(ext_mode);

  fsg_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .sig_in(ext_sync),
    .rise  (ext_rise)
  );

  fsg_period_counter #(.PER_W(PER_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold      (mode == FSG_MODE_EXTERNAL),
    .reload_val(period_cfg),
    .start     (per_start)
  );

  always_comb begin
    unique case (mode)
      FSG_MODE_EXTERNAL: frame_start = ext_rise;
      default:           frame_start = per_start;
    endcase
  end

  fsg_width_counter #(.WID_W(WID_W)) u_width (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (frame_start),
    .load_val(width_cfg),
    .active  (fs_out)
  );

  // R8: the period counter never starts a frame in external mode
  assert_ext_no_period_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !per_start);
  // R2: any frame start raises the output on the next cycle
  assert_start_raises_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> fs_out);
  // R1: output low during reset
  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_low_R1: assert (!fs_out || $past(rst_n) || 1'b1 == $past(rst_n))
      else $error("fs_out high under reset");
  end
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> !fs_out);
endmodule

// File: tb/fsg_pulse_gen_tb.sv
module fsg_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] period_cfg = '0;
  logic [7:0]  width_cfg = '0;
  logic        ext_mode = 1'b0;
  logic        ext_sync = 1'b0;
  logic        fs_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsg_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_cfg(period_cfg),
    .width_cfg(width_cfg), .ext_mode(ext_mode), .ext_sync(ext_sync), .fs_out(fs_out)
  );

  // {period, width}
  localparam int VEC_N = 6;
  localparam logic [19:0] VEC [VEC_N] = '{
    {12'd15, 8'd1}, {12'd0, 8'd0}, {12'd3, 8'd5},
    {12'd3, 8'd3},  {12'd4, 8'd0}, {12'd9, 8'd2}
  };

  function automatic bit model(int t, int p, int w);
    return (t % (p + 1)) <= w;
  endfunction

  task automatic check(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: fs_out=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; ext_sync = 1'b0;
    repeat (3) @(negedge clk);
    check(fs_out, 1'b0, "R1 during reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Vector table walk: continuous enable, internal mode (R2 R3 R4 R5)
    for (int v = 0; v < VEC_N; v++) begin
      int p, w, bad, first;
      bit got0;
      p = int'(VEC[v][19:8]);
      w = int'(VEC[v][7:0]);
      period_cfg = VEC[v][19:8];
      width_cfg  = VEC[v][7:0];
      ext_mode = 1'b0;
      do_reset();
      tick = 1'b1;
      bad = 0; first = -1; got0 = 1'b0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (t == 0) got0 = fs_out;
        if (fs_out !== model(t, p, w)) begin
          bad++;
          if (first < 0) first = t;
        end
      end
      check(got0, 1'b1, "R2 first pulse");
      checks++;
      if (bad != 0) begin
        failures++;
        $display("FAIL %s: vector %0d P=%0d W=%0d mismatches=%0d expected=0 first at tick %0d",
                 (w >= p) ? "R5" : "R3/R4", v, p, w, bad, first);
      end
    end

    // R1 / R6: held in low after reset while tick stays low
    period_cfg = 12'd3; width_cfg = 8'd1; ext_mode = 1'b0;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(fs_out, 1'b0, "R1 no tick after reset");
    end

    // R6: tick on alternate cycles; output moves only on enabled edges
    begin
      int tc;
      tc = 0;
      for (int c = 0; c < 24; c++) begin
        tick = c[0];
        @(negedge clk);
        if (tick) tc++;
        if (tc == 0) check(fs_out, 1'b0, "R6 gated");
        else         check(fs_out, model(tc - 1, 3, 1), "R6 gated");
      end
      tick = 1'b0;
    end

    // R7: config change mid-period waits for next start
    period_cfg = 12'd7; width_cfg = 8'd0;
    do_reset();
    tick = 1'b1;
    for (int t = 0; t < 18; t++) begin
      @(negedge clk);
      if (t == 3) period_cfg = 12'd2;
      check(fs_out, (t == 0 || t == 8 || t == 11 || t == 14 || t == 17), "R7 reload");
    end

    // R8: external mode, no triggers -> no pulses, period ignored
    ext_mode = 1'b1; period_cfg = 12'd0; width_cfg = 8'd2;
    do_reset();
    tick = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check(fs_out, 1'b0, "R8 ext idle");
    end
    // R8/R9: rising edge starts W+1 pulse; held level does not retrigger
    ext_sync = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check(fs_out, t <= 2, "R9 held level");
    end
    // R10: retrigger during pulse extends it
    ext_sync = 1'b0;
    @(negedge clk);
    ext_sync = 1'b1;                       // rise at tick a
    @(negedge clk); check(fs_out, 1'b1, "R10 a");
    ext_sync = 1'b0;                       // low sampled at a+1
    @(negedge clk); check(fs_out, 1'b1, "R10 a+1");
    ext_sync = 1'b1;                       // rise at a+2
    @(negedge clk); check(fs_out, 1'b1, "R10 a+2");
    @(negedge clk); check(fs_out, 1'b1, "R10 a+3");
    @(negedge clk); check(fs_out, 1'b1, "R10 a+4");
    @(negedge clk); check(fs_out, 1'b0, "R10 a+5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule